// File: doc/BRIEF.md
# Serial Transmitter with Idle Preamble

This block is a double-buffered asynchronous serial transmitter. Software writes a frame into a holding register; on a bit-time tick the frame moves into a shift register and goes out on the line. Frames carry either 8 or 9 data bits. Baud generation sits outside the block. A single-cycle `bit_tick` input marks every bit boundary, and all line activity advances only on that tick.

Turning the enable on, or toggling it off and on again while a frame is shifting, queues an idle preamble. The preamble is a run of mark bit times. When it is queued during a frame, it follows that frame's stop bit directly. Software uses this to separate two messages by the smallest possible idle gap. Two flags report the transmitter's progress: holding register empty and transmission complete. Each flag has its own interrupt enable, and both feed one interrupt output. While the transmitter does not own the line, the pin carries a general-purpose port bit. This lets a steady mark be held while the transmitter is off.

Top module: `sertx_preamble`

## Requirements
- R1: A frame is a 0 start bit, then the data bits least significant first (8 bits when `nine_bit` is 0, bits 8:0 when it is 1), then a 1 stop bit. Each bit is held from one `bit_tick` to the next. The length is taken when the frame is loaded.
- R2: After reset, `dr_empty` = 1 and `tx_done` = 1, and `txd` follows `port_bit`.
- R3: While `tx_done` = 1, a rise of `tx_en` clears `tx_done` at once and starts a preamble of 10 mark ticks (11 when `nine_bit` = 1) before any frame.
- R4: A write with `tx_en` = 1 stores `wdata` and clears `dr_empty`. On the tick where the frame moves into the shift register, `dr_empty` sets again and the start bit begins.
- R5: If the holding register is full when a stop bit ends, the next frame's start bit follows with no gap.
- R6: If `tx_en` is cleared and set again while a frame shifts, that frame completes through its stop bit, and a preamble (10 or 11 ticks) follows at once.
- R7: When a preamble ends and the holding register is empty, the line stays at mark. A later write starts a frame at the next tick.
- R8: With `tx_en` = 0, the transmitter releases the line when the current frame or preamble ends, or at once if it is only marking. `tx_done` then sets and `txd` follows `port_bit`.
- R9: Clearing `tx_en` discards an unsent frame in the holding register (`dr_empty` = 1). A write while `tx_en` = 0 is ignored.
- R10: `irq` = 1 exactly when (`dr_empty` and `empty_ie`) or (`tx_done` and `done_ie`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous reset, active low |
| bit_tick | input | 1 | one-cycle pulse per bit time |
| nine_bit | input | 1 | 1 selects 9 data bits |
| tx_en | input | 1 | transmitter enable |
| wr | input | 1 | write strobe for the holding register |
| wdata | input | 9 | frame data |
| empty_ie | input | 1 | interrupt enable for holding register empty |
| done_ie | input | 1 | interrupt enable for transmission complete |
| port_bit | input | 1 | general-purpose value driven on the line while released |
| txd | output | 1 | serial line |
| dr_empty | output | 1 | holding register empty flag |
| tx_done | output | 1 | transmission complete flag |
| irq | output | 1 | interrupt request |

## Verification
Register-driven results appear in the cycle after the clock edge that samples their cause: `dr_empty` after a write, disable or load; `tx_done` after an enable rise or release; `txd` after a tick. `irq`, and `txd` while released, follow `port_bit` and the enables in the same cycle. The bench drives inputs at the falling edge. Its reference model updates at the rising edge from those inputs, and all four outputs are compared 2 ns after every rising edge, so each result is checked in the cycle it is due. The scenarios cover both frame lengths, back-to-back frames, an enable toggle during a frame, an idle gap after a preamble, release with different port values, and discard.

// File: rtl/sertx_preamble.sv
module sertx_preamble #(
  parameter int DW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_tick,
  input  logic          nine_bit,
  input  logic          tx_en,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  input  logic          empty_ie,
  input  logic          done_ie,
  input  logic          port_bit,
  output logic          txd,
  output logic          dr_empty,
  output logic          tx_done,
  output logic          irq
);
  localparam int SW = DW + 2;
  localparam int CW = $clog2(SW + 2);

  typedef enum logic [1:0] {S_OFF, S_MARK, S_PRE, S_DATA} st_t;

  st_t           state;
  logic [DW-1:0] hold;
  logic          full;
  logic [SW-1:0] shreg;
  logic [CW-1:0] idx, last, cnt, pre_last;
  logic          pend, en_q;

  wire rise     = tx_en & ~en_q;
  wire pend_eff = pend | (rise & (state == S_DATA));
  wire stop_end = (state == S_DATA) & bit_tick & (idx == last);
  wire pre_end  = (state == S_PRE) & bit_tick & (cnt == pre_last);
  wire load     = tx_en & full &
                  (((state == S_MARK) & bit_tick) | (stop_end & ~pend_eff) | pre_end);

  wire [CW-1:0] frame_last = nine_bit ? CW'(DW + 1) : CW'(DW);
  wire [CW-1:0] pre_len_m1 = nine_bit ? CW'(DW + 1) : CW'(DW);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_OFF;
      shreg    <= '1;
      idx      <= '0;
      last     <= '0;
      cnt      <= '0;
      pre_last <= '0;
      pend     <= 1'b0;
      en_q     <= 1'b0;
    end else begin
      en_q <= tx_en;
      if (load) begin
        state <= S_DATA;
        idx   <= '0;
        last  <= frame_last;
        shreg <= nine_bit ? {1'b1, hold, 1'b0} : {2'b11, hold[DW-2:0], 1'b0};
      end else begin
        case (state)
          S_OFF: if (rise) begin
            state    <= S_PRE;
            cnt      <= '0;
            pre_last <= pre_len_m1;
          end
          S_MARK: if (!tx_en) state <= S_OFF;
          S_PRE: if (bit_tick) begin
            if (cnt == pre_last) state <= tx_en ? S_MARK : S_OFF;
            else cnt <= cnt + 1'b1;
          end
          S_DATA: begin
            pend <= pend_eff;
            if (bit_tick) begin
              if (idx == last) begin
                if (pend_eff) begin
                  state    <= S_PRE;
                  cnt      <= '0;
                  pre_last <= pre_len_m1;
                  pend     <= 1'b0;
                end else begin
                  state <= tx_en ? S_MARK : S_OFF;
                end
              end else begin
                idx   <= idx + 1'b1;
                shreg <= {1'b1, shreg[SW-1:1]};
              end
            end
          end
          default: state <= S_OFF;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0;
      hold <= '0;
    end else if (!tx_en) begin
      full <= 1'b0;
    end else if (wr) begin
      full <= 1'b1;
      hold <= wdata;
    end else if (load) begin
      full <= 1'b0;
    end
  end

  assign txd      = (state == S_OFF) ? port_bit : (state == S_DATA) ? shreg[0] : 1'b1;
  assign dr_empty = ~full;
  assign tx_done  = (state == S_OFF);
  assign irq      = (dr_empty & empty_ie) | (tx_done & done_ie);
endmodule

module sertx_preamble_chk (
  input logic clk,
  input logic rst_n,
  input logic tx_en,
  input logic wr,
  input logic port_bit,
  input logic txd,
  input logic dr_empty,
  input logic tx_done,
  input logic irq
);
  AST_RELEASED_PORT: assert property (@(posedge clk) disable iff (!rst_n) tx_done |-> txd == port_bit); // R8
  AST_WRITE_FILLS: assert property (@(posedge clk) disable iff (!rst_n) wr && tx_en |=> !dr_empty); // R4
  AST_DISABLE_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n) !tx_en |=> dr_empty); // R9
  AST_START_MARK: assert property (@(posedge clk) disable iff (!rst_n) $fell(tx_done) |-> txd); // R3
  AST_RELEASE_NEEDS_OFF: assert property (@(posedge clk) disable iff (!rst_n) $rose(tx_done) |-> !$past(tx_en)); // R8
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !dr_empty && !tx_done |-> !irq); // R10
endmodule

bind sertx_preamble sertx_preamble_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .wr(wr), .port_bit(port_bit),
  .txd(txd), .dr_empty(dr_empty), .tx_done(tx_done), .irq(irq)
);

// File: tb/sertx_preamble_bench.sv
module sertx_preamble_bench;
  logic       clk = 0, rst_n = 0;
  logic       bit_tick = 0, nine_bit = 0, tx_en = 0, wr = 0;
  logic [8:0] wdata = '0;
  logic       empty_ie = 0, done_ie = 0, port_bit = 1;
  logic       txd, dr_empty, tx_done, irq;

  int checks = 0, errors = 0, cycles = 0;
  string cur_req = "R2";
  bit tick_on = 0;
  int tdiv = 0;

  sertx_preamble u_sertx_preamble (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .nine_bit(nine_bit),
    .tx_en(tx_en), .wr(wr), .wdata(wdata), .empty_ie(empty_ie),
    .done_ie(done_ie), .port_bit(port_bit), .txd(txd),
    .dr_empty(dr_empty), .tx_done(tx_done), .irq(irq)
  );

  always #5 clk = ~clk;

  // tick generator: one pulse every 4 cycles
  always @(negedge clk) begin
    if (tick_on) begin
      tdiv = (tdiv + 1) % 4;
      bit_tick = (tdiv == 0);
    end else bit_tick = 0;
  end

  // behavioural reference model
  bit m_on, m_full, m_pend, m_inframe, m_en_prev;
  bit [8:0] m_data;
  bit q[$];

  task automatic push_pre(bit nine);
    for (int i = 0; i < (nine ? 11 : 10); i++) q.push_back(1'b1);
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_on = 0; m_full = 0; m_pend = 0; m_inframe = 0; m_en_prev = 0; m_data = '0;
      q.delete();
    end else begin
      bit rise, do_load;
      bit [8:0] d;
      rise = tx_en && !m_en_prev;
      do_load = 0;
      d = m_data;
      if (!m_on) begin
        if (rise) begin push_pre(nine_bit); m_on = 1; m_inframe = 0; end
      end else begin
        if (rise && m_inframe) m_pend = 1;
        if (q.size() == 0) begin
          if (!tx_en) m_on = 0;
          else if (bit_tick && m_full) do_load = 1;
        end else if (bit_tick) begin
          void'(q.pop_front());
          if (q.size() == 0) begin
            if (m_pend) begin push_pre(nine_bit); m_pend = 0; m_inframe = 0; end
            else if (!tx_en) m_on = 0;
            else if (m_full) do_load = 1;
            else m_inframe = 0;
          end
        end
      end
      if (do_load) begin
        q.push_back(1'b0);
        for (int i = 0; i < (nine_bit ? 9 : 8); i++) q.push_back(d[i]);
        q.push_back(1'b1);
        m_inframe = 1;
        m_full = 0;
      end
      if (!tx_en) m_full = 0;
      else if (wr) begin m_full = 1; m_data = wdata; end
      m_en_prev = tx_en;
    end
  end

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #2;
    cycles++;
    if (rst_n) begin
      bit e_txd, e_empty, e_done;
      e_txd   = m_on ? (q.size() ? q[0] : 1'b1) : port_bit;
      e_empty = !m_full;
      e_done  = !m_on;
      check(cur_req, "txd", txd, e_txd);
      check(cur_req, "dr_empty", dr_empty, e_empty);
      check(cur_req, "tx_done", tx_done, e_done);
      check("R10", "irq", irq, (e_empty && empty_ie) || (e_done && done_ie));
    end
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 100000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write(logic [8:0] v);
    @(negedge clk); wr = 1; wdata = v;
    @(negedge clk); wr = 0;
  endtask

  task automatic wait_empty();
    while (!dr_empty) @(negedge clk);
  endtask

  task automatic wait_done();
    while (!tx_done) @(negedge clk);
  endtask

  initial begin
    idle(2);
    check("R2", "txd", txd, 1);
    check("R2", "dr_empty", dr_empty, 1);
    check("R2", "tx_done", tx_done, 1);
    port_bit = 0; #1;
    check("R2", "txd follows port", txd, 0);
    @(negedge clk); rst_n = 1; tick_on = 1;

    cur_req = "R9"; write(9'h055); idle(2);
    check("R9", "write while off", dr_empty, 1);

    cur_req = "R3"; port_bit = 1; empty_ie = 1; done_ie = 1;
    @(negedge clk); tx_en = 1;
    cur_req = "R1"; write(9'h0A5);
    idle(30);
    cur_req = "R5"; write(9'h03C); wait_empty(); write(9'h0C3); wait_empty();
    cur_req = "R6"; idle(6); tx_en = 0; @(negedge clk); tx_en = 1;
    write(9'h081); idle(120);
    cur_req = "R7"; idle(40); write(9'h011); idle(60);

    cur_req = "R1"; nine_bit = 1; empty_ie = 0;
    write(9'h1A5); wait_empty();
    cur_req = "R6"; idle(5); tx_en = 0; @(negedge clk); tx_en = 1;
    write(9'h10F); idle(160);

    cur_req = "R8"; nine_bit = 0; done_ie = 1; empty_ie = 1;
    write(9'h0F0); wait_empty(); idle(6); tx_en = 0; port_bit = 0;
    wait_done(); idle(4);
    check("R8", "released txd", txd, 0);

    cur_req = "R9"; @(negedge clk); tx_en = 1; write(9'h022); write(9'h044);
    @(negedge clk); tx_en = 0; @(negedge clk);
    check("R9", "discard", dr_empty, 1);
    wait_done(); idle(8);
    cur_req = "R8"; @(negedge clk); tx_en = 1; idle(70); tx_en = 0; idle(4);
    check("R8", "mark release", tx_done, 1);
    idle(4);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule